// File: doc/BRIEF.md
# Two-Line Handshake Waveform Generator

This block borrows the clock and data lines of an open-drain two-wire bus for a short while and drives a timed pattern on them that is not a bus transfer. A target device detects this pattern and switches into a special receive mode. After the pattern ends, the block hands the pins back to the normal two-wire bus controller through a line-select output that steers the pin multiplexer.

A `start_i` pulse runs one fixed sequence with three phases. First both lines hold static levels. Next, two free-running square waves of different frequency run together. Last, both lines hold static levels again so the target's clock can settle. A prescaler divides the system clock into a 1 MHz tick, and every period and phase length is counted in those ticks. Each static level is expressed as a 0% or full-period duty value on the same compare path that the waveforms use. The phase lengths in milliseconds, the waveform frequencies and all four static levels are parameters.

Top module: `hs_wavegen`

## Requirements
- R1: During and after reset, with no sequence running, `busy_o`, `done_o` and `take_lines_o` are 0, and both line outputs are 1 (released).
- R2: A `start_i` sampled high while idle sets `busy_o` and `take_lines_o` to 1 from the next cycle on. The same edge clears the prescaler and both period counters, so that tick n of the sequence ends CLK_HZ/TICK_HZ·(n+1) cycles after that edge.
- R3: For the first PRE_MS·TICKS_PER_MS ticks, the clock line holds PRE_CLK_LVL and the data line holds PRE_DAT_LVL.
- R4: During the next WAVE_MS·TICKS_PER_MS ticks, the clock line is 1 exactly when (t mod CP) < CP/2, where t counts ticks from the start and CP = TICK_HZ/CLK_LINE_HZ.
- R5: During the same phase, the data line is 1 exactly when (t mod DP) < DP/2 (integer half), where DP = TICK_HZ/DAT_LINE_HZ.
- R6: For the next POST_MS·TICKS_PER_MS ticks, the clock line holds POST_CLK_LVL and the data line holds POST_DAT_LVL.
- R7: When the last post tick completes, `busy_o` and `take_lines_o` drop to 0, both lines return to 1, and `done_o` is 1 for exactly that one cycle.
- R8: A `start_i` that arrives while busy has no effect on the running sequence.
- R9: A new start after completion repeats the identical sequence from tick zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Request to run one handshake sequence |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse when the lines are handed back |
| take_lines_o | output | 1 | 1: pins driven by this block, 0: pins belong to the bus controller |
| clk_line_o | output | 1 | Level for the clock line |
| dat_line_o | output | 1 | Level for the data line |

## Verification
Every output is a registered value or a compare of registered values. The result of the edge that samples the start therefore appears one cycle later. From then on the state after edge k is fixed by t = k / (CLK_HZ/TICK_HZ), so phase boundaries, waveform levels and the done pulse all fall on exact cycle numbers. The bench counts edges from the start edge and samples every output on the falling edge that follows each one. It compares each sample against a value computed from t for every cycle of the sequence and for two cycles beyond its end. A phase length that is not a multiple of either waveform period makes sure the counters run from the start and not from the phase entry.

// File: rtl/hs_wavegen.sv
module hs_wavegen #(
  parameter int CLK_HZ       = 48_000_000,
  parameter int TICK_HZ      = 1_000_000,
  parameter int CLK_LINE_HZ  = 100_000,
  parameter int DAT_LINE_HZ  = 200_000,
  parameter int TICKS_PER_MS = 1000,
  parameter int PRE_MS       = 5,
  parameter int WAVE_MS      = 50,
  parameter int POST_MS      = 10,
  parameter bit PRE_CLK_LVL  = 1'b0,
  parameter bit PRE_DAT_LVL  = 1'b0,
  parameter bit POST_CLK_LVL = 1'b0,
  parameter bit POST_DAT_LVL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  output logic busy_o,
  output logic done_o,
  output logic take_lines_o,
  output logic clk_line_o,
  output logic dat_line_o
);
  localparam int DIV    = CLK_HZ / TICK_HZ;
  localparam int CPER   = TICK_HZ / CLK_LINE_HZ;
  localparam int DPER   = TICK_HZ / DAT_LINE_HZ;
  localparam int PRE_T  = PRE_MS * TICKS_PER_MS;
  localparam int WAVE_T = WAVE_MS * TICKS_PER_MS;
  localparam int POST_T = POST_MS * TICKS_PER_MS;
  localparam int MAX_T  = (PRE_T > WAVE_T) ? ((PRE_T > POST_T) ? PRE_T : POST_T)
                                           : ((WAVE_T > POST_T) ? WAVE_T : POST_T);
  localparam int DW = $clog2(DIV + 1);
  localparam int CW = $clog2(CPER + 1);
  localparam int EW = $clog2(DPER + 1);
  localparam int PW = $clog2(MAX_T + 1);

  typedef enum logic [1:0] {S_IDLE, S_PRE, S_WAVE, S_POST} st_t;

  st_t           st_q;
  logic [DW-1:0] div_q;
  logic [PW-1:0] ph_q, ph_len;
  logic [CW-1:0] cc_q, cduty_q;
  logic [EW-1:0] dc_q, dduty_q;
  logic          done_q;

  wire tick    = (st_q != S_IDLE) && (div_q == DW'(DIV - 1));
  wire ph_last = tick && (ph_q == ph_len - PW'(1));

  always_comb begin
    case (st_q)
      S_PRE:   ph_len = PW'(PRE_T);
      S_WAVE:  ph_len = PW'(WAVE_T);
      default: ph_len = PW'(POST_T);
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      div_q   <= '0;
      ph_q    <= '0;
      cc_q    <= '0;
      dc_q    <= '0;
      cduty_q <= '0;
      dduty_q <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (st_q == S_IDLE) begin
        if (start_i) begin
          st_q    <= S_PRE;
          div_q   <= '0;
          ph_q    <= '0;
          cc_q    <= '0;
          dc_q    <= '0;
          cduty_q <= PRE_CLK_LVL ? CW'(CPER) : '0;
          dduty_q <= PRE_DAT_LVL ? EW'(DPER) : '0;
        end
      end else begin
        div_q <= tick ? '0 : div_q + DW'(1);
        if (tick) begin
          cc_q <= (cc_q == CW'(CPER - 1)) ? '0 : cc_q + CW'(1);
          dc_q <= (dc_q == EW'(DPER - 1)) ? '0 : dc_q + EW'(1);
          ph_q <= ph_last ? '0 : ph_q + PW'(1);
        end
        if (ph_last) begin
          case (st_q)
            S_PRE: begin
              st_q    <= S_WAVE;
              cduty_q <= CW'(CPER / 2);
              dduty_q <= EW'(DPER / 2);
            end
            S_WAVE: begin
              st_q    <= S_POST;
              cduty_q <= POST_CLK_LVL ? CW'(CPER) : '0;
              dduty_q <= POST_DAT_LVL ? EW'(DPER) : '0;
            end
            default: begin
              st_q   <= S_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
      end
    end
  end

  assign busy_o       = (st_q != S_IDLE);
  assign take_lines_o = busy_o;
  assign done_o       = done_q;
  assign clk_line_o   = busy_o ? (cc_q < cduty_q) : 1'b1;
  assign dat_line_o   = busy_o ? (dc_q < dduty_q) : 1'b1;
endmodule

module hs_wavegen_chk (
  input logic clk,
  input logic rst_n,
  input logic start_i,
  input logic busy_o,
  input logic done_o,
  input logic take_lines_o,
  input logic clk_line_o,
  input logic dat_line_o
);
  a_r1_idle_released: assert property (@(posedge clk) disable iff (!rst_n)
    !take_lines_o |-> (clk_line_o && dat_line_o));
  a_r2_start_takes_lines: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy_o && start_i) |=> (busy_o && take_lines_o));
  a_r7_done_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!busy_o && $past(busy_o)));
  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  a_r7_busy_ends_with_done: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy_o) |-> done_o);
endmodule

bind hs_wavegen hs_wavegen_chk u_chk (.*);

// File: tb/hs_wavegen_bench.sv
module hs_wavegen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int DIV  = 3;
  localparam int TPM  = 7;
  localparam int PT   = 2 * TPM;
  localparam int WT   = 5 * TPM;
  localparam int QT   = 1 * TPM;
  localparam int TT   = PT + WT + QT;
  localparam int CP   = 10;
  localparam int DP   = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_i = 1'b0;
  logic busy_o, done_o, take_lines_o, clk_line_o, dat_line_o;
  int checks = 0;
  int errors = 0;
  int cycles = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hs_wavegen #(
    .CLK_HZ(3_000_000), .TICK_HZ(1_000_000), .CLK_LINE_HZ(100_000),
    .DAT_LINE_HZ(200_000), .TICKS_PER_MS(TPM), .PRE_MS(2), .WAVE_MS(5),
    .POST_MS(1), .PRE_CLK_LVL(1'b1), .PRE_DAT_LVL(1'b0),
    .POST_CLK_LVL(1'b0), .POST_DAT_LVL(1'b1)
  ) u_hs_wavegen (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .take_lines_o(take_lines_o),
    .clk_line_o(clk_line_o), .dat_line_o(dat_line_o)
  );

  wire [4:0] obs = {busy_o, done_o, take_lines_o, clk_line_o, dat_line_o};

  task automatic chk(input logic [4:0] act, input logic [4:0] exp, input string req, input int k);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s at k=%0d: actual %b expected %b (busy,done,sel,clk,dat)", req, k, act, exp);
    end
  endtask

  function automatic logic [4:0] expv(input int k, output string req);
    int t;
    t = k / DIV;
    if (t < PT) begin req = "R3"; return 5'b10110; end
    if (t < PT + WT) begin
      req = ((t % CP) < CP / 2) == ((t % DP) < DP / 2) ? "R4" : "R5";
      return {3'b101, 1'((t % CP) < CP / 2), 1'((t % DP) < DP / 2)};
    end
    if (t < TT) begin req = "R6"; return 5'b10101; end
    req = "R7";
    if (k == TT * DIV) return 5'b01011;
    return 5'b00011;
  endfunction

  task automatic run_seq(input string tag);
    string req;
    logic [4:0] e;
    @(negedge clk) start_i = 1'b1;
    @(negedge clk) start_i = 1'b0;
    chk(obs, 5'b10110, {"R2 ", tag}, 0);
    for (int k = 1; k <= TT * DIV + 2; k++) begin
      if (k == 61) start_i = 1'b1;
      if (k == 62) start_i = 1'b0;
      @(negedge clk);
      e = expv(k, req);
      if (k >= 62 && k < TT * DIV) req = {req, " R8"};
      chk(obs, e, {req, " ", tag}, k);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000) begin
      errors++;
      $display("FAIL watchdog: actual %0d cycles expected under 5000", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(obs, 5'b00011, "R1 in reset", -1);
    rst_n = 1'b1;
    @(negedge clk);
    chk(obs, 5'b00011, "R1 after reset", -1);
    run_seq("run1");
    repeat (4) @(negedge clk);
    chk(obs, 5'b00011, "R1 idle between runs", -1);
    run_seq("R9 run2");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule